// File: doc/BRIEF.md
# Seconds Watchdog with Frequency Fallback

This block guards the frequency-programming path of a clock synthesizer. Software programs one 8-bit control byte. The byte holds a timeout of 0 to 15 seconds, a fallback policy, a fast-test switch, the role of a shared pin, and a sticky expiry flag. A prescaler divides the reference clock down to a one-second tick. Once armed, a down-counter spends the programmed number of seconds. Software keeps the system alive by writing the control byte again with a non-zero timeout before the count runs out. If it fails to do so, the block raises the expiry flag and drives an active-low reset pulse of fixed length on the shared pin.

The block also records the last two frequency codes that software wrote. A watchdog expiry means the latest code probably hung the system. After an expiry the block therefore reports a fallback code: either the board-strapped code or the code written before the latest one, as the policy bit selects. A reset through the block's own reset input never applies that fallback. It returns everything to the strapped code.

Top module: `wdr_top`

## Requirements
- R1: A control write whose timeout field (bits 3:0) is 0 turns the watchdog off. No expiry follows, the flag stays 0 and the reset pin stays high for as long as no non-zero timeout is written.
- R2: A control write with timeout N (1..15) causes expiry exactly N*TICK_DIV reference cycles after the write edge. At expiry the flag (control byte bit 7) reads 1 and the reset output goes low.
- R3: A control write with a non-zero timeout restarts the full interval, counted from that write, so regular writes prevent expiry.
- R4: The flag is sticky. Control writes with a non-zero timeout leave it unchanged, whatever value they give bit 7. Only a write with timeout 0 clears it.
- R5: After expiry the reset output stays low for exactly RST_CYCLES reference cycles and then returns high. No further expiry occurs until a new non-zero timeout is written.
- R6: With control bit 6 at 0 the shared pin is an output: `pinOe`=1 and `pwrDownN`=1. With bit 6 at 1 the pin is an input: `pinOe`=0 and `pwrDownN` follows `pinIn`.
- R7: Before any expiry, `freqSel` equals the most recently written software frequency code. If no code has been written since reset, it equals `strapFreq`.
- R8: When the policy bit (control bit 4) is 0 at expiry, `freqSel` shows `strapFreq` from the expiry edge onward.
- R9: When the policy bit is 1 at expiry, `freqSel` shows the code written before the most recent one. If fewer than two codes have been written, it shows `strapFreq`.
- R10: A low level on `rstN` clears the control byte to 0x00 and the code history. Afterwards `freqSel` shows `strapFreq`, with no fallback.
- R11: With control bit 5 at 1, the timeout counts reference cycles instead of seconds: timeout N expires N cycles after the write.
- R12: The first frequency write after an expiry ends the fallback, and `freqSel` shows the new code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlWrEn | input | 1 | Control byte write strobe |
| ctrlWrData | input | 8 | Control byte write value |
| ctrlByte | output | 8 | Current control byte including flag in bit 7 |
| freqWrEn | input | 1 | Software frequency code write strobe |
| freqWrData | input | FREQ_W | Software frequency code |
| strapFreq | input | FREQ_W | Board-strapped frequency code |
| freqSel | output | FREQ_W | Frequency code in effect |
| pinIn | input | 1 | Level seen on the shared pin |
| pinOe | output | 1 | Shared pin output enable |
| pinOutN | output | 1 | Active-low reset pulse onto the shared pin |
| pwrDownN | output | 1 | Active-low power-down request from the pin |

## Verification
The bench builds the block with TICK_DIV=8 and RST_CYCLES=4, so that a "second" lasts eight cycles. With these values every timeout, every servicing write and the full reset pulse fit into a few hundred cycles. Each boundary can then be checked on its exact cycle: one cycle before expiry, the expiry edge, and the last cycle of the pulse. The fast-test bit is also exercised, so the one-cycle tick path is covered alongside the divided one.

// File: rtl/wdr_pkg.sv
package wdr_pkg;
  localparam int TO_W = 4;

  typedef struct packed {
    logic            reload;
    logic            stop;
    logic            expire;
    logic            pushFreq;
    logic            testMode;
    logic            revertPol;
    logic [TO_W-1:0] loadVal;
  } wdrStrobe_t;

  typedef struct packed {
    logic tickNow;
    logic cntAtOne;
    logic rstActive;
  } wdrStat_t;
endpackage

// File: rtl/wdr_ctrl.sv
module wdr_ctrl
  import wdr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWrEn,
  input  logic [7:0] ctrlWrData,
  input  logic       freqWrEn,
  input  wdrStat_t   dpStat,
  output wdrStrobe_t strb,
  output logic [7:0] ctrlByte,
  output logic       pinDir
);
  logic [TO_W-1:0] toSel;
  logic            revertPol;
  logic            testMode;
  logic            alarm;
  logic            wrZero;
  logic            expireNow;

  assign wrZero    = (ctrlWrData[TO_W-1:0] == '0);
  assign expireNow = dpStat.tickNow & dpStat.cntAtOne & ~ctrlWrEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toSel     <= '0;
      revertPol <= 1'b0;
      testMode  <= 1'b0;
      pinDir    <= 1'b0;
      alarm     <= 1'b0;
    end else begin
      if (ctrlWrEn) begin
        toSel     <= ctrlWrData[TO_W-1:0];
        revertPol <= ctrlWrData[4];
        testMode  <= ctrlWrData[5];
        pinDir    <= ctrlWrData[6];
      end
      if (ctrlWrEn && wrZero)
        alarm <= 1'b0;
      else if (expireNow)
        alarm <= 1'b1;
    end
  end

  always_comb begin
    strb           = '0;
    strb.reload    = ctrlWrEn & ~wrZero;
    strb.stop      = ctrlWrEn & wrZero;
    strb.loadVal   = ctrlWrData[TO_W-1:0];
    strb.expire    = expireNow;
    strb.pushFreq  = freqWrEn;
    strb.testMode  = testMode;
    strb.revertPol = revertPol;
  end

  assign ctrlByte = {alarm, pinDir, testMode, revertPol, toSel};

  AST_ALARM_SET: assert property (@(posedge clk) disable iff (!rstN)
    strb.expire |=> alarm); // R2
  AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (alarm && !(ctrlWrEn && wrZero)) |=> alarm); // R4
  AST_ALARM_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrEn && wrZero) |=> !alarm); // R4
  AST_SINGLE_EXPIRE: assert property (@(posedge clk) disable iff (!rstN)
    strb.expire |=> !strb.expire); // R5
endmodule

// File: rtl/wdr_datapath.sv
module wdr_datapath
  import wdr_pkg::*;
#(
  parameter int TICK_DIV   = 32768,
  parameter int RST_CYCLES = 16,
  parameter int FREQ_W     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  wdrStrobe_t        strb,
  input  logic [FREQ_W-1:0] freqWrData,
  input  logic [FREQ_W-1:0] strapFreq,
  output wdrStat_t          dpStat,
  output logic [FREQ_W-1:0] freqSel
);
  localparam int PS_W   = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int RC_W   = $clog2(RST_CYCLES + 1);
  localparam int HIST_N = 2;
  localparam logic [PS_W-1:0] PS_LAST = PS_W'(TICK_DIV - 1);
  localparam logic [RC_W-1:0] RC_LOAD = RC_W'(RST_CYCLES);

  logic [PS_W-1:0] presc;
  logic [TO_W-1:0] secCnt;
  logic [RC_W-1:0] rstCnt;
  logic            psWrap;
  logic            tickNow;

  logic [FREQ_W-1:0] hist    [HIST_N];
  logic              histVld [HIST_N];
  logic              revertActive;
  logic              revertUseSw;

  generate
    if (TICK_DIV > 1) begin : g_div
      assign psWrap = (presc == PS_LAST);
    end else begin : g_nodiv
      assign psWrap = 1'b1;
    end
  endgenerate

  assign tickNow = strb.testMode | psWrap;

  // prescaler, restarted by every servicing write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    presc <= '0;
    else if (strb.reload || psWrap) presc <= '0;
    else                          presc <= presc + 1'b1;
  end

  // seconds down-counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            secCnt <= '0;
    else if (strb.reload)                 secCnt <= strb.loadVal;
    else if (strb.stop)                   secCnt <= '0;
    else if (tickNow && secCnt != '0)     secCnt <= secCnt - 1'b1;
  end

  // reset pulse length counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rstCnt <= '0;
    else if (strb.expire)   rstCnt <= RC_LOAD;
    else if (rstCnt != '0)  rstCnt <= rstCnt - 1'b1;
  end

  // two-entry history of software frequency codes
  for (genvar i = 0; i < HIST_N; i++) begin : g_hist
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        hist[i]    <= '0;
        histVld[i] <= 1'b0;
      end else if (strb.pushFreq) begin
        if (i == 0) begin
          hist[i]    <= freqWrData;
          histVld[i] <= 1'b1;
        end else begin
          hist[i]    <= hist[i-1];
          histVld[i] <= histVld[i-1];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      revertActive <= 1'b0;
      revertUseSw  <= 1'b0;
    end else if (strb.expire) begin
      revertActive <= 1'b1;
      revertUseSw  <= strb.revertPol;
    end else if (strb.pushFreq) begin
      revertActive <= 1'b0;
    end
  end

  always_comb begin
    if (revertActive) begin
      if (revertUseSw && histVld[1]) freqSel = hist[1];
      else                           freqSel = strapFreq;
    end else if (histVld[0]) begin
      freqSel = hist[0];
    end else begin
      freqSel = strapFreq;
    end
  end

  assign dpStat.tickNow   = tickNow;
  assign dpStat.cntAtOne  = (secCnt == TO_W'(1));
  assign dpStat.rstActive = (rstCnt != '0);

  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (secCnt == '0 && !strb.reload) |=> secCnt == '0); // R1
  AST_RELOAD_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.reload |=> (secCnt == $past(strb.loadVal))); // R3
  AST_PULSE_START: assert property (@(posedge clk) disable iff (!rstN)
    strb.expire |=> dpStat.rstActive); // R5
  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    strb.pushFreq |=> (hist[1] == $past(hist[0]))); // R9
  AST_FALLBACK_STRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.expire && !strb.revertPol && !strb.pushFreq) |=> freqSel == strapFreq); // R8
endmodule

// File: rtl/wdr_top.sv
module wdr_top
  import wdr_pkg::*;
#(
  parameter int TICK_DIV   = 32768,
  parameter int RST_CYCLES = 16,
  parameter int FREQ_W     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic [7:0]        ctrlWrData,
  output logic [7:0]        ctrlByte,
  input  logic              freqWrEn,
  input  logic [FREQ_W-1:0] freqWrData,
  input  logic [FREQ_W-1:0] strapFreq,
  output logic [FREQ_W-1:0] freqSel,
  input  logic              pinIn,
  output logic              pinOe,
  output logic              pinOutN,
  output logic              pwrDownN
);
  wdrStrobe_t strb;
  wdrStat_t   dpStat;
  logic       pinDir;

  wdr_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ctrlWrEn   (ctrlWrEn),
    .ctrlWrData (ctrlWrData),
    .freqWrEn   (freqWrEn),
    .dpStat     (dpStat),
    .strb       (strb),
    .ctrlByte   (ctrlByte),
    .pinDir     (pinDir)
  );

  wdr_datapath #(
    .TICK_DIV   (TICK_DIV),
    .RST_CYCLES (RST_CYCLES),
    .FREQ_W     (FREQ_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .freqWrData (freqWrData),
    .strapFreq  (strapFreq),
    .dpStat     (dpStat),
    .freqSel    (freqSel)
  );

  assign pinOe    = ~pinDir;
  assign pinOutN  = ~dpStat.rstActive;
  assign pwrDownN = pinDir ? pinIn : 1'b1;

  AST_PULSE_ON_PIN: assert property (@(posedge clk) disable iff (!rstN)
    strb.expire |=> !pinOutN); // R2
endmodule

// File: tb/wdr_top_bench.sv
module wdr_top_bench;
  localparam int P   = 8;
  localparam int RC  = 4;
  localparam int FW  = 4;
  localparam logic [FW-1:0] STRAP = 4'hA;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          ctrlWrEn = 1'b0;
  logic [7:0]    ctrlWrData = '0;
  logic [7:0]    ctrlByte;
  logic          freqWrEn = 1'b0;
  logic [FW-1:0] freqWrData = '0;
  logic [FW-1:0] freqSel;
  logic          pinIn = 1'b1;
  logic          pinOe, pinOutN, pwrDownN;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  wdr_top #(.TICK_DIV(P), .RST_CYCLES(RC), .FREQ_W(FW)) u_wdr_top (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .ctrlByte(ctrlByte), .freqWrEn(freqWrEn), .freqWrData(freqWrData),
    .strapFreq(STRAP), .freqSel(freqSel), .pinIn(pinIn), .pinOe(pinOe),
    .pinOutN(pinOutN), .pwrDownN(pwrDownN)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrCtrl(input logic [7:0] v);
    ctrlWrEn = 1'b1; ctrlWrData = v;
    @(posedge clk); @(negedge clk);
    ctrlWrEn = 1'b0;
  endtask

  task automatic wrFreq(input logic [FW-1:0] v);
    freqWrEn = 1'b1; freqWrData = v;
    @(posedge clk); @(negedge clk);
    freqWrEn = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    check(ctrlByte == 8'h00, "R10 ctrl after reset", ctrlByte, 0);
    check(pinOutN == 1'b1, "R10 pin idle", pinOutN, 1);
    check(pinOe == 1'b1 && pwrDownN == 1'b1, "R6 default output role", {pinOe, pwrDownN}, 3);
    check(freqSel == STRAP, "R7 strap with no sw code", freqSel, STRAP);
  endtask

  task automatic t_off();
    int lows = 0;
    wrCtrl(8'h00);
    for (int i = 0; i < 20 * P; i++) begin
      @(negedge clk);
      if (!pinOutN || ctrlByte[7]) lows++;
    end
    check(lows == 0, "R1 off never expires", lows, 0);
  endtask

  task automatic t_timeout();
    int extra = 0;
    wrCtrl(8'h02);
    cyc(2 * P - 1);
    check(ctrlByte[7] == 1'b0 && pinOutN, "R2 no expiry one cycle early", ctrlByte[7], 0);
    cyc(1);
    check(ctrlByte[7] == 1'b1, "R2 flag at expiry", ctrlByte[7], 1);
    check(pinOutN == 1'b0, "R2 reset low at expiry", pinOutN, 0);
    cyc(RC - 1);
    check(pinOutN == 1'b0, "R5 reset still low last cycle", pinOutN, 0);
    cyc(1);
    check(pinOutN == 1'b1, "R5 reset released", pinOutN, 1);
    for (int i = 0; i < 40 * P; i++) begin
      @(negedge clk);
      if (!pinOutN) extra++;
    end
    check(extra == 0, "R5 no second expiry", extra, 0);
  endtask

  task automatic t_sticky();
    wrCtrl(8'h0F);
    check(ctrlByte[7] == 1'b1, "R4 nonzero write keeps flag", ctrlByte[7], 1);
    wrCtrl(8'h8F);
    check(ctrlByte[7] == 1'b1, "R4 bit7 write ignored", ctrlByte[7], 1);
    wrCtrl(8'h80);
    check(ctrlByte[7] == 1'b0, "R4 zero timeout clears", ctrlByte[7], 0);
  endtask

  task automatic t_service();
    int lows = 0;
    wrCtrl(8'h01);
    for (int k = 0; k < 5; k++) begin
      cyc(P - 3);
      wrCtrl(8'h01);
    end
    cyc(P - 1);
    check(ctrlByte[7] == 1'b0 && pinOutN, "R3 serviced, no expiry", ctrlByte[7], 0);
    cyc(1);
    check(ctrlByte[7] == 1'b1, "R3 expiry one interval after last write", ctrlByte[7], 1);
    cyc(RC + 2);
    wrCtrl(8'h00);
    lows = pinOutN ? 0 : 1;
    check(lows == 0, "R5 pin high after pulse", pinOutN, 1);
  endtask

  task automatic t_test();
    wrCtrl(8'h23);
    cyc(2);
    check(ctrlByte[7] == 1'b0, "R11 fast mode not early", ctrlByte[7], 0);
    cyc(1);
    check(ctrlByte[7] == 1'b1, "R11 fast mode expires after 3 cycles", ctrlByte[7], 1);
    cyc(RC + 2);
    wrCtrl(8'h00);
  endtask

  task automatic t_pin();
    wrCtrl(8'h40);
    pinIn = 1'b0; cyc(1);
    check(pinOe == 1'b0, "R6 input role disables drive", pinOe, 0);
    check(pwrDownN == 1'b0, "R6 power-down follows pin low", pwrDownN, 0);
    pinIn = 1'b1; cyc(1);
    check(pwrDownN == 1'b1, "R6 power-down follows pin high", pwrDownN, 1);
    wrCtrl(8'h00);
    pinIn = 1'b0; cyc(1);
    check(pinOe == 1'b1 && pwrDownN == 1'b1, "R6 output role ignores pin", {pinOe, pwrDownN}, 3);
    pinIn = 1'b1;
  endtask

  task automatic t_freq();
    doReset();
    wrFreq(4'h3);
    check(freqSel == 4'h3, "R7 latest code", freqSel, 3);
    wrFreq(4'h5);
    check(freqSel == 4'h5, "R7 newer code", freqSel, 5);
    wrCtrl(8'h01);
    cyc(P);
    check(freqSel == STRAP, "R8 policy 0 gives strap", freqSel, STRAP);
    cyc(RC + 2);
    wrFreq(4'h7);
    check(freqSel == 4'h7, "R12 new write ends fallback", freqSel, 7);
    wrFreq(4'h9);
    wrFreq(4'hC);
    wrCtrl(8'h11);
    cyc(P - 1);
    check(freqSel == 4'hC, "R9 latest code until expiry", freqSel, 4'hC);
    cyc(1);
    check(freqSel == 4'h9, "R9 policy 1 gives previous code", freqSel, 9);
    cyc(RC + 2);
    doReset();
    check(freqSel == STRAP && ctrlByte == 8'h00, "R10 reset gives strap, no fallback", freqSel, STRAP);
    wrFreq(4'h6);
    wrCtrl(8'h11);
    cyc(P);
    check(freqSel == STRAP, "R9 single code falls back to strap", freqSel, STRAP);
    cyc(RC + 2);
  endtask

  initial begin
    fork
      begin
        cyc(3);
        rstN = 1'b1;
        cyc(1);
        t_reset();
        t_off();
        t_timeout();
        t_sticky();
        t_service();
        t_test();
        t_pin();
        t_freq();
      end
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule